// File: doc/BRIEF.md
# Multi-Stream Synchronous Start Controller

This block gates the link traffic of every stream of a multi-channel audio DMA link formatter. It holds one programmed synchronization bit per stream. Each stream's bit is combined with that stream's run flag and FIFO-ready flag to produce a per-stream link enable. While a stream's committed sync bit is set, the stream is held off the link, even if it is running.

Software sets the sync bits of a group of streams and then starts their engines. It then clears all of the group's bits in a single write. The cleared bits wait in the programmed register and are committed together on the next frame-start strobe, so every stream in the group moves its first sample in the same frame. A synchronous stop uses the reverse order: software sets the sync bits, which take hold at the next frame boundary, and then clears the run flags. Grouping is only meaningful for streams that share one link segment and its frame strobe.

A stream is released at a frame boundary only when its run and FIFO-ready flags are both high at that boundary. Clearing a sync bit while either flag is low raises a sticky per-stream error flag. The stream then stays held until the first frame boundary at which both flags are high.

Top module: `stream_sync_gate`

## Requirements
- R1: After reset the programmed register reads as zero. A full write stores data bits [NUM_STREAMS-1:0], with bit i belonging to stream i. Reads return those bits, and bits [31:NUM_STREAMS] always read as zero.
- R2: A write updates the register only when all four byte strobes are set (wr_strb = 4'hF). A write with any strobe clear leaves the readback unchanged.
- R3: While stream i's committed sync bit is 1, link_en[i] is 0 whatever run[i] and fifo_rdy[i] are.
- R4: A stream whose sync bit has never been set has link_en[i] equal to run[i] in the same cycle, with no wait for a frame strobe.
- R5: All sync bits cleared by one write are committed together at the next frame_start cycle, and the affected link_en bits rise in the cycle after that strobe.
- R6: A cleared sync bit is committed at a frame_start only if run[i] and fifo_rdy[i] are both 1 in that cycle. Otherwise the stream stays held until the first frame_start at which both are 1.
- R7: A full write that takes bit i from 1 to 0 while run[i] or fifo_rdy[i] is 0 sets sync_err[i]. The flag stays set until reset.
- R8: Setting a sync bit holds the stream from the next frame_start on, regardless of run[i]. Until that strobe, link_en[i] keeps its value.
- R9: A write in the same cycle as frame_start takes effect only at the following frame_start.
- R10: link_en[i] is 0 in any cycle in which run[i] is 0, with no frame delay.
- R11: Reads return the programmed bits, not the committed state, so a pending release or hold shows at once on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_strb | input | 4 | Byte strobes of the write; all four must be set |
| wr_data | input | 32 | Write data; bit i is stream i's sync bit |
| rd_data | output | 32 | Programmed sync bits, upper bits zero |
| run | input | NUM_STREAMS | Per-stream run flags |
| fifo_rdy | input | NUM_STREAMS | Per-stream FIFO-ready flags |
| frame_start | input | 1 | One-cycle strobe at each full link frame boundary |
| link_en | output | NUM_STREAMS | Per-stream permission to move data on the link |
| sync_err | output | NUM_STREAMS | Sticky flags for releases requested without run and FIFO-ready |

## Verification
The bench builds the block with its defaults: 19 streams in a 32-bit register. This leaves thirteen reserved bits that a write of all ones tries to set, and a stream group spread over the whole width. Split releases of low and high groups, a stop of a middle group, and a release with one stream's FIFO not ready all fall within the same register. These cases show that grouping, deferral and error capture act per bit and not on the word as a whole.

// File: rtl/stream_sync_pkg.sv
// Package: shared constants and types of the synchronous start controller.
// Assumes a register width that is a whole number of bytes.
package stream_sync_pkg;
    localparam int unsigned REG_W_DEF   = 32;
    localparam int unsigned STREAMS_DEF = 19;

    // Committed gate state of one stream
    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HELD = 1'b1
    } gate_state_e;
endpackage

// File: rtl/stream_sync_csr.sv
// Module: programmed sync register. It takes full-width writes only and
// returns the programmed bits, zero-extended, on the read port.
// Assumes REG_W is a multiple of 8 and NUM_STREAMS <= REG_W.
module stream_sync_csr #(
    parameter int unsigned REG_W       = 32,
    parameter int unsigned NUM_STREAMS = 19,
    localparam int unsigned STRB_W     = REG_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [STRB_W-1:0]      wr_strb,
    input  logic [REG_W-1:0]       wr_data,
    output logic                   wr_fire,
    output logic [NUM_STREAMS-1:0] prog_q,
    output logic [REG_W-1:0]       rd_data
);
    // Accept a write only when every byte lane is enabled
    assign wr_fire = wr_en & (&wr_strb);

    // Store the programmed sync bits
    always_ff @(posedge clk) begin
        if (!rst_n)       prog_q <= '0;
        else if (wr_fire) prog_q <= wr_data[NUM_STREAMS-1:0];
    end

    // Readback zero-extends the programmed bits
    assign rd_data = REG_W'(prog_q);

    generate
        if (NUM_STREAMS < REG_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wr_data[REG_W-1:NUM_STREAMS];
        end
    endgenerate

    a_r1_full_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> prog_q == $past(wr_data[NUM_STREAMS-1:0]));
    a_r2_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(&wr_strb)) |=> $stable(prog_q));
endmodule

// File: rtl/stream_gate_cell.sv
// Module: gate of one stream. It commits the programmed sync bit at frame
// boundaries, waits for run and FIFO-ready before a release, and records
// releases requested too early. Assumes frame_start is a one-cycle strobe.
module stream_gate_cell
    import stream_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic wr_fire,
    input  logic wr_bit,
    input  logic prog_bit,
    input  logic run,
    input  logic fifo_rdy,
    output logic link_en,
    output logic held,
    output logic sync_err
);
    gate_state_e state_q, state_d;
    logic        ready;
    logic        early_clear;

    assign ready = run & fifo_rdy;

    // Next committed state: hold on a set bit, release only when ready
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            if (prog_bit)                        state_d = GATE_HELD;
            else if (state_q == GATE_HELD && ready) state_d = GATE_OPEN;
        end
    end

    // Commit register, updated only by the frame strobe
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    // A 1-to-0 write while the stream is not ready is an error
    assign early_clear = wr_fire & prog_bit & ~wr_bit & ~ready;

    // Sticky error flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)           sync_err <= 1'b0;
        else if (early_clear) sync_err <= 1'b1;
    end

    assign held    = (state_q == GATE_HELD);
    assign link_en = run & ~held;

    a_r5_commit_on_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(state_q));
    a_r6_no_release_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (held && frame_start && !(run && fifo_rdy)) |=> held);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);
    a_r8_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && prog_bit) |=> held);
endmodule

// File: rtl/stream_sync_gate.sv
// Module: top of the synchronous start controller. It ties the programmed
// register to one gate cell per stream. Assumes every stream it serves
// shares one link segment and its frame_start strobe.
module stream_sync_gate #(
    parameter int unsigned REG_W       = stream_sync_pkg::REG_W_DEF,
    parameter int unsigned NUM_STREAMS = stream_sync_pkg::STREAMS_DEF,
    localparam int unsigned STRB_W     = REG_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [STRB_W-1:0]      wr_strb,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       rd_data,
    input  logic [NUM_STREAMS-1:0] run,
    input  logic [NUM_STREAMS-1:0] fifo_rdy,
    input  logic                   frame_start,
    output logic [NUM_STREAMS-1:0] link_en,
    output logic [NUM_STREAMS-1:0] sync_err
);
    logic                   wr_fire;
    logic [NUM_STREAMS-1:0] prog_q;
    logic [NUM_STREAMS-1:0] held;

    stream_sync_csr #(
        .REG_W       (REG_W),
        .NUM_STREAMS (NUM_STREAMS)
    ) i_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .wr_fire (wr_fire),
        .prog_q  (prog_q),
        .rd_data (rd_data)
    );

    // One gate cell per stream
    generate
        for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_cell
            stream_gate_cell i_cell (
                .clk         (clk),
                .rst_n       (rst_n),
                .frame_start (frame_start),
                .wr_fire     (wr_fire),
                .wr_bit      (wr_data[s]),
                .prog_bit    (prog_q[s]),
                .run         (run[s]),
                .fifo_rdy    (fifo_rdy[s]),
                .link_en     (link_en[s]),
                .held        (held[s]),
                .sync_err    (sync_err[s])
            );
        end
    endgenerate

    a_r3_held_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en & held) == '0);
    a_r10_no_en_without_run: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en & ~run) == '0);
endmodule

// File: tb/test_stream_sync_gate.sv
module test_stream_sync_gate;
    localparam int N = 19;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_strb = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  run = '0;
    logic [N-1:0]  fifo_rdy = '0;
    logic          frame_start = 1'b0;
    logic [N-1:0]  link_en;
    logic [N-1:0]  sync_err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    stream_sync_gate i_stream_sync_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_data(wr_data), .rd_data(rd_data), .run(run), .fifo_rdy(fifo_rdy),
        .frame_start(frame_start), .link_en(link_en), .sync_err(sync_err)
    );

    // Vector: {sync to write, run, fifo_rdy, expected link_en after frame}
    localparam logic [4*N-1:0] VECS [6] = '{
        {19'h7FFFF, 19'h00000, 19'h00000, 19'h00000},
        {19'h7FFFF, 19'h7FFFF, 19'h7FFFF, 19'h00000},
        {19'h7FFF0, 19'h7FFFF, 19'h7FFFF, 19'h0000F},
        {19'h00000, 19'h7FFFF, 19'h7FFFF, 19'h7FFFF},
        {19'h00F00, 19'h7FFFF, 19'h7FFFF, 19'h7F0FF},
        {19'h00000, 19'h7FFFF, 19'h7FFFF, 19'h7FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic [3:0] s, input logic with_frame);
        @(negedge clk);
        wr_en = 1'b1; wr_strb = s; wr_data = d; frame_start = with_frame;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; frame_start = 1'b0;
    endtask

    task automatic do_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset readback", rd_data, 32'h0);
        check("R1 reset link_en", 32'(link_en), 32'h0);

        // Table walk: grouped holds, split releases, stop of a middle group
        for (int v = 0; v < 6; v++) begin
            logic [N-1:0] s_v, r_v, f_v, e_v;
            {s_v, r_v, f_v, e_v} = VECS[v];
            @(negedge clk);
            run = r_v; fifo_rdy = f_v;
            do_write(32'(s_v), 4'hF, 1'b0);
            check("R1 table readback", rd_data, 32'(s_v));
            do_frame();
            check("R5 table link_en after frame", 32'(link_en), 32'(e_v));
            check("R7 table no error", 32'(sync_err), 32'h0);
        end

        // R4 / R10: stream without sync follows run at once
        do_reset();
        @(negedge clk);
        run = 19'h00001; fifo_rdy = '0;
        #1 check("R4 enable follows run", 32'(link_en), 32'h1);
        run = '0;
        #1 check("R10 enable drops with run", 32'(link_en), 32'h0);

        // R2: partial write is ignored
        do_write(32'hFFFF_FFFF, 4'h7, 1'b0);
        check("R2 partial write ignored", rd_data, 32'h0);

        // R1 / R11 / R8: full write, reserved bits zero, hold waits for frame
        @(negedge clk);
        run = ALL; fifo_rdy = ALL;
        do_write(32'hFFFF_FFFF, 4'hF, 1'b0);
        check("R1 reserved bits read zero", rd_data, 32'h0007_FFFF);
        check("R11 read shows programmed before commit", 32'(link_en), 32'(ALL));
        do_frame();
        check("R8 hold after frame", 32'(link_en), 32'h0);
        check("R3 held despite run and ready", 32'(link_en), 32'h0);

        // R9: write on the strobe cycle waits a frame
        do_write(32'h0, 4'hF, 1'b1);
        check("R11 readback after clear", rd_data, 32'h0);
        check("R9 write on strobe deferred", 32'(link_en), 32'h0);
        do_frame();
        check("R9 release at following frame", 32'(link_en), 32'(ALL));

        // R6 / R7: release requested while one FIFO is not ready
        do_write(32'h0007_FFFF, 4'hF, 1'b0);
        do_frame();
        @(negedge clk);
        fifo_rdy = ALL & ~19'h00020;
        do_write(32'h0, 4'hF, 1'b0);
        check("R7 error on early clear", 32'(sync_err), 32'h20);
        do_frame();
        check("R6 unready stream stays held", 32'(link_en), 32'(ALL & ~19'h00020));
        @(negedge clk);
        fifo_rdy = ALL;
        #1 check("R6 no release without frame", 32'(link_en), 32'(ALL & ~19'h00020));
        do_frame();
        check("R6 release at first ready frame", 32'(link_en), 32'(ALL));
        check("R7 error stays sticky", 32'(sync_err), 32'h20);

        // R1 / R7: reset clears register and errors
        do_reset();
        check("R7 reset clears error", 32'(sync_err), 32'h0);
        check("R1 reset clears register", rd_data, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule